// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

The walker turns a request made of a process identifier and a virtual page number into a physical frame number. It uses one global table that is shared by every process and holds one entry per physical frame. No frame number is stored in that table. The frame number is the index of the entry whose process identifier and virtual page number both equal the request. A small anchor table, indexed by a hash of the request, gives the first entry of a collision chain. Each entry links to the next entry of its chain through a pointer, and the walker follows these pointers one synchronous read per cycle.

Both tables sit in internal synchronous RAMs. A load port fills them while the walker is idle. The lookup side uses a valid/ready request and a one-cycle response pulse. The response carries hit, error, the frame number, the entry's access bits, the number of entries visited, and the translated address, in which the page offset passes through unchanged. By default the block has 64 frames and 16 anchor slots. The frame index width is a parameter and can be set to 17 for 512 MB of 4 KB pages.

The controller has four states. IDLE accepts a request (IDLE→ANCHOR). ANCHOR reads the anchor slot: if the slot is valid it goes to ENTRY, otherwise it goes to DONE. ENTRY compares one entry per cycle. It goes to DONE on a match, at the end of the chain or at the step bound, and otherwise stays in ENTRY and follows the link. DONE presents the response and returns to IDLE.

Top module: `ipt_walker`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request reads anchor slot h. Bit j of h is the XOR of every bit i of the key {pid, vpn} with i mod ANCHOR_AW = j. The vpn occupies the low key bits.
- R3: When the first chain entry matches in both pid and vpn, the response is rsp_hit=1, rsp_err=0, rsp_ppn = that entry's index, rsp_acc = its access bits, rsp_steps=1, and rsp_paddr = {rsp_ppn, req_off}.
- R4: An entry that matches only the vpn, or only the pid, is skipped. The walk follows the links, and a match at the k-th entry reports rsp_steps=k.
- R5: An anchor slot whose valid bit is 0 ends the lookup with a miss: rsp_hit=0, rsp_err=0, rsp_steps=0, rsp_ppn=0.
- R6: The walk ends with a miss (rsp_err=0, rsp_ppn=0) at a non-matching entry whose link-valid bit is 0, or at an entry whose valid bit is 0. Such an entry counts as one step.
- R7: After 2^FRAME_AW entries have been visited without a match, the walk ends with rsp_hit=0, rsp_err=1 and rsp_steps=2^FRAME_AW. A cyclic chain therefore always terminates.
- R8: `req_ready` is 0 from the cycle after acceptance until the response. `rsp_valid` lasts exactly one cycle. A request presented while busy is ignored.
- R9: Load-port writes presented while a walk is in progress are dropped.
- R10: A write to an anchor slot in the cycle that accepts a request reading that slot does not affect that lookup, which sees the old content. The next lookup sees the new content.
- R11: With k entries visited, `rsp_valid` rises right after the (1+k)-th clock edge following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle, request accepted when valid |
| req_pid | input | 16 | Requesting process identifier |
| req_vpn | input | 52 | Virtual page number |
| req_off | input | 12 | Page offset, passed to the address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_err | output | 1 | Step bound reached |
| rsp_ppn | output | FRAME_AW | Frame number (matching entry index) |
| rsp_acc | output | 12 | Access bits of the matching entry |
| rsp_paddr | output | FRAME_AW+12 | Frame number concatenated with offset |
| rsp_steps | output | STEP_W | Entries visited |
| ld_anchor_we | input | 1 | Anchor slot write strobe |
| ld_anchor_idx | input | ANCHOR_AW | Anchor slot index |
| ld_anchor_valid | input | 1 | Slot valid bit |
| ld_anchor_ptr | input | FRAME_AW | First entry of the chain |
| ld_entry_we | input | 1 | Entry write strobe |
| ld_entry_idx | input | FRAME_AW | Entry index (frame number) |
| ld_entry_valid | input | 1 | Entry valid bit |
| ld_entry_pid | input | 16 | Owner process identifier |
| ld_entry_vpn | input | 52 | Mapped virtual page number |
| ld_entry_acc | input | 12 | Access bits |
| ld_entry_nvalid | input | 1 | Link valid bit |
| ld_entry_next | input | FRAME_AW | Next entry of the chain |

## Verification
Two functions can fall in one cycle: a load-port write and the acceptance of a request. The bench provokes this at the start of a lookup by invalidating the very anchor slot that the request hashes to. It judges the outcome from two consecutive lookups: the first must still hit through the old slot content, and the second must miss with zero steps. The second case is a load write and a stray request arriving in the middle of a long walk on a cyclic chain. Both must leave no trace. This is judged from the absence of a second response and from the unchanged access bits on a later lookup.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    parameter int PID_W = 16;
    parameter int VPN_W = 52;
    parameter int ACC_W = 12;
    parameter int OFF_W = 12;
    localparam int KEY_W = PID_W + VPN_W;
    localparam int TAG_W = PID_W + VPN_W + ACC_W;

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic [ACC_W-1:0] acc;
    } ipt_tag_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ANCHOR,
        ST_ENTRY,
        ST_DONE
    } walk_state_e;

endpackage

// File: rtl/ipt_sram.sv
module ipt_sram #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // read-first: a same-cycle write is not seen by the read
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/ipt_match.sv
module ipt_match
    import ipt_pkg::*;
(
    input  logic [PID_W-1:0] key_pid,
    input  logic [VPN_W-1:0] key_vpn,
    input  logic             ent_valid,
    input  logic             ent_nvalid,
    input  ipt_tag_t         ent_tag,
    output logic             is_hit,
    output logic             is_last
);
    always_comb begin
        is_hit  = ent_valid && (ent_tag.pid == key_pid) && (ent_tag.vpn == key_vpn);
        is_last = !ent_valid || !ent_nvalid;
    end
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
    import ipt_pkg::*;
#(
    parameter int FRAME_AW = 6,
    parameter int ANCHOR_AW = 4,
    localparam int DEPTH = 1 << FRAME_AW,
    localparam int STEP_W = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [PID_W-1:0]          req_pid,
    input  logic [VPN_W-1:0]          req_vpn,
    input  logic [OFF_W-1:0]          req_off,
    output logic                      rsp_valid,
    output logic                      rsp_hit,
    output logic                      rsp_err,
    output logic [FRAME_AW-1:0]       rsp_ppn,
    output logic [ACC_W-1:0]          rsp_acc,
    output logic [FRAME_AW+OFF_W-1:0] rsp_paddr,
    output logic [STEP_W-1:0]         rsp_steps,
    input  logic                      ld_anchor_we,
    input  logic [ANCHOR_AW-1:0]      ld_anchor_idx,
    input  logic                      ld_anchor_valid,
    input  logic [FRAME_AW-1:0]       ld_anchor_ptr,
    input  logic                      ld_entry_we,
    input  logic [FRAME_AW-1:0]       ld_entry_idx,
    input  logic                      ld_entry_valid,
    input  logic [PID_W-1:0]          ld_entry_pid,
    input  logic [VPN_W-1:0]          ld_entry_vpn,
    input  logic [ACC_W-1:0]          ld_entry_acc,
    input  logic                      ld_entry_nvalid,
    input  logic [FRAME_AW-1:0]       ld_entry_next
);
    localparam int AW_W = 1 + FRAME_AW;
    localparam int EW_W = 2 + FRAME_AW + TAG_W;
    localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(DEPTH);

    function automatic logic [ANCHOR_AW-1:0] fold_key(input logic [KEY_W-1:0] key);
        logic [ANCHOR_AW-1:0] h;
        h = '0;
        for (int i = 0; i < KEY_W; i++) h[i % ANCHOR_AW] ^= key[i];
        return h;
    endfunction

    walk_state_e state_q, state_d;

    logic [PID_W-1:0]    pid_q;
    logic [VPN_W-1:0]    vpn_q;
    logic [OFF_W-1:0]    off_q;
    logic [STEP_W-1:0]   steps_q;
    logic [FRAME_AW-1:0] cur_q;
    logic                hit_q, err_q;
    logic [FRAME_AW-1:0] ppn_q;
    logic [ACC_W-1:0]    acc_q;
    logic [STEP_W-1:0]   rsteps_q;

    logic                accept, idle;
    logic [AW_W-1:0]     a_rdata;
    logic                a_valid;
    logic [FRAME_AW-1:0] a_ptr;
    logic [EW_W-1:0]     e_rdata, e_wdata;
    logic                e_valid, e_nvalid;
    logic [FRAME_AW-1:0] e_next;
    ipt_tag_t            e_tag, ld_tag;
    logic                e_hit, e_last, e_bound;
    logic [STEP_W-1:0]   steps_nxt;
    logic                e_re;
    logic [FRAME_AW-1:0] e_raddr;

    assign idle   = (state_q == ST_IDLE);
    assign accept = idle && req_valid;

    assign {a_valid, a_ptr} = a_rdata;
    assign {e_valid, e_nvalid, e_next, e_tag} = e_rdata;

    assign ld_tag  = '{pid: ld_entry_pid, vpn: ld_entry_vpn, acc: ld_entry_acc};
    assign e_wdata = {ld_entry_valid, ld_entry_nvalid, ld_entry_next, ld_tag};

    ipt_sram #(.W(AW_W), .AW(ANCHOR_AW)) anchor_ram_i (
        .clk   (clk),
        .we    (ld_anchor_we && idle),
        .waddr (ld_anchor_idx),
        .wdata ({ld_anchor_valid, ld_anchor_ptr}),
        .re    (accept),
        .raddr (fold_key({req_pid, req_vpn})),
        .rdata (a_rdata)
    );

    ipt_match match_i (
        .key_pid    (pid_q),
        .key_vpn    (vpn_q),
        .ent_valid  (e_valid),
        .ent_nvalid (e_nvalid),
        .ent_tag    (e_tag),
        .is_hit     (e_hit),
        .is_last    (e_last)
    );

    assign steps_nxt = steps_q + 1'b1;
    assign e_bound   = (steps_nxt == STEP_MAX);

    always_comb begin
        e_re    = 1'b0;
        e_raddr = e_next;
        if (state_q == ST_ANCHOR) begin
            e_re    = a_valid;
            e_raddr = a_ptr;
        end else if (state_q == ST_ENTRY) begin
            e_re    = !(e_hit || e_last || e_bound);
        end
    end

    ipt_sram #(.W(EW_W), .AW(FRAME_AW)) entry_ram_i (
        .clk   (clk),
        .we    (ld_entry_we && idle),
        .waddr (ld_entry_idx),
        .wdata (e_wdata),
        .re    (e_re),
        .raddr (e_raddr),
        .rdata (e_rdata)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_ANCHOR;
            ST_ANCHOR: state_d = a_valid ? ST_ENTRY : ST_DONE;
            ST_ENTRY:  if (e_hit || e_last || e_bound) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q    <= '0;
            vpn_q    <= '0;
            off_q    <= '0;
            steps_q  <= '0;
            cur_q    <= '0;
            hit_q    <= 1'b0;
            err_q    <= 1'b0;
            ppn_q    <= '0;
            acc_q    <= '0;
            rsteps_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        pid_q   <= req_pid;
                        vpn_q   <= req_vpn;
                        off_q   <= req_off;
                        steps_q <= '0;
                    end
                end
                ST_ANCHOR: begin
                    cur_q <= a_ptr;
                    if (!a_valid) begin
                        hit_q    <= 1'b0;
                        err_q    <= 1'b0;
                        ppn_q    <= '0;
                        acc_q    <= '0;
                        rsteps_q <= '0;
                    end
                end
                ST_ENTRY: begin
                    steps_q <= steps_nxt;
                    cur_q   <= e_next;
                    if (e_hit) begin
                        hit_q    <= 1'b1;
                        err_q    <= 1'b0;
                        ppn_q    <= cur_q;
                        acc_q    <= e_tag.acc;
                        rsteps_q <= steps_nxt;
                    end else if (e_last || e_bound) begin
                        hit_q    <= 1'b0;
                        err_q    <= !e_last;
                        ppn_q    <= '0;
                        acc_q    <= '0;
                        rsteps_q <= steps_nxt;
                    end
                end
                ST_DONE: begin
                end
            endcase
        end
    end

    assign req_ready = idle;
    assign rsp_valid = (state_q == ST_DONE);
    assign rsp_hit   = hit_q;
    assign rsp_err   = err_q;
    assign rsp_ppn   = ppn_q;
    assign rsp_acc   = acc_q;
    assign rsp_steps = rsteps_q;
    assign rsp_paddr = {ppn_q, off_q};

endmodule

// File: rtl/ipt_walker_chk.sv
module ipt_walker_chk #(
    parameter int FRAME_AW = 6,
    localparam int DEPTH = 1 << FRAME_AW,
    localparam int STEP_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_err,
    input logic [STEP_W-1:0] rsp_steps
);
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R8
    AST_RSP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R8
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (!rsp_err && rsp_steps != '0)); // R3
    AST_ERR_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!rsp_hit && rsp_steps == STEP_W'(DEPTH))); // R7
    AST_STEPS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_steps <= STEP_W'(DEPTH))); // R7
endmodule

bind ipt_walker ipt_walker_chk #(.FRAME_AW(FRAME_AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_err   (rsp_err),
    .rsp_steps (rsp_steps)
);

// File: tb/ipt_walker_tb_top.sv
module ipt_walker_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FAW = 6;
    localparam int AAW = 4;
    localparam int NFR = 1 << FAW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [15:0] req_pid = '0;
    logic [51:0] req_vpn = '0;
    logic [11:0] req_off = '0;
    logic rsp_valid, rsp_hit, rsp_err;
    logic [FAW-1:0] rsp_ppn;
    logic [11:0] rsp_acc;
    logic [FAW+11:0] rsp_paddr;
    logic [6:0] rsp_steps;
    logic ld_anchor_we = 1'b0;
    logic [AAW-1:0] ld_anchor_idx = '0;
    logic ld_anchor_valid = 1'b0;
    logic [FAW-1:0] ld_anchor_ptr = '0;
    logic ld_entry_we = 1'b0;
    logic [FAW-1:0] ld_entry_idx = '0;
    logic ld_entry_valid = 1'b0;
    logic [15:0] ld_entry_pid = '0;
    logic [51:0] ld_entry_vpn = '0;
    logic [11:0] ld_entry_acc = '0;
    logic ld_entry_nvalid = 1'b0;
    logic [FAW-1:0] ld_entry_next = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipt_walker #(.FRAME_AW(FAW), .ANCHOR_AW(AAW)) dut_i (.*);

    // lookup results
    bit  r_hit, r_err;
    longint r_ppn, r_acc, r_steps, r_paddr;
    int  r_edges;

    function automatic logic [AAW-1:0] model_slot(input logic [15:0] p, input logic [51:0] v);
        logic [67:0] k;
        logic [AAW-1:0] h;
        k = {p, v};
        h = '0;
        for (int i = 0; i < 68; i++) h[i % AAW] = h[i % AAW] ^ k[i];
        return h;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_anchor(input logic [AAW-1:0] idx, input bit v, input logic [FAW-1:0] ptr);
        @(negedge clk);
        ld_anchor_we = 1'b1; ld_anchor_idx = idx; ld_anchor_valid = v; ld_anchor_ptr = ptr;
        @(negedge clk);
        ld_anchor_we = 1'b0;
    endtask

    task automatic load_entry(input logic [FAW-1:0] idx, input bit v, input logic [15:0] p,
                              input logic [51:0] vp, input logic [11:0] acc,
                              input bit nv, input logic [FAW-1:0] nxt);
        @(negedge clk);
        ld_entry_we = 1'b1; ld_entry_idx = idx; ld_entry_valid = v; ld_entry_pid = p;
        ld_entry_vpn = vp; ld_entry_acc = acc; ld_entry_nvalid = nv; ld_entry_next = nxt;
        @(negedge clk);
        ld_entry_we = 1'b0;
    endtask

    task automatic wait_rsp();
        r_edges = 0;
        for (int n = 0; n < 400; n++) begin
            @(posedge clk);
            r_edges++;
            @(negedge clk);
            if (rsp_valid) break;
        end
        r_hit = rsp_hit; r_err = rsp_err; r_ppn = rsp_ppn; r_acc = rsp_acc;
        r_steps = rsp_steps; r_paddr = rsp_paddr;
    endtask

    task automatic lookup(input logic [15:0] p, input logic [51:0] v, input logic [11:0] off,
                          input bit kill, input logic [AAW-1:0] kslot);
        @(negedge clk);
        req_valid = 1'b1; req_pid = p; req_vpn = v; req_off = off;
        if (kill) begin
            ld_anchor_we = 1'b1; ld_anchor_idx = kslot; ld_anchor_valid = 1'b0; ld_anchor_ptr = '0;
        end
        @(negedge clk);
        req_valid = 1'b0; ld_anchor_we = 1'b0;
        wait_rsp();
    endtask

    task automatic t_reset();
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_first_hit();
        lookup(16'h1, 52'h10, 12'h5A5, 1'b0, '0);
        chk("R3 hit", r_hit, 1);
        chk("R3 err", r_err, 0);
        chk("R3 ppn", r_ppn, 5);
        chk("R3 acc", r_acc, 12'hABC);
        chk("R3 paddr", r_paddr, {6'd5, 12'h5A5});
        chk("R3 steps", r_steps, 1);
        chk("R11 latency one step", r_edges, 2);
    endtask

    task automatic t_chain();
        lookup(16'h1, 52'h01, 12'h0, 1'b0, '0);
        chk("R4 hit", r_hit, 1);
        chk("R4 ppn", r_ppn, 20);
        chk("R4 steps", r_steps, 3);
        chk("R2 R11 latency three steps", r_edges, 4);
    endtask

    task automatic t_anchor_invalid();
        lookup(16'h2, 52'h10, 12'h0, 1'b0, '0);
        chk("R5 hit", r_hit, 0);
        chk("R5 err", r_err, 0);
        chk("R5 steps", r_steps, 0);
        chk("R5 ppn", r_ppn, 0);
        chk("R11 latency zero steps", r_edges, 1);
    endtask

    task automatic t_chain_end();
        lookup(16'h1, 52'h32, 12'h0, 1'b0, '0);
        chk("R6 null link hit", r_hit, 0);
        chk("R6 null link err", r_err, 0);
        chk("R6 null link steps", r_steps, 3);
        chk("R6 null link ppn", r_ppn, 0);
        lookup(16'h0, 52'h4, 12'h0, 1'b0, '0);
        chk("R6 invalid entry hit", r_hit, 0);
        chk("R6 invalid entry err", r_err, 0);
        chk("R6 invalid entry steps", r_steps, 1);
    endtask

    task automatic t_cycle_busy();
        int extra;
        @(negedge clk);
        req_valid = 1'b1; req_pid = 16'h0; req_vpn = 52'h8; req_off = '0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 ready low while walking", req_ready, 0);
        req_valid = 1'b1; req_pid = 16'h1; req_vpn = 52'h10;
        ld_entry_we = 1'b1; ld_entry_idx = 6'd5; ld_entry_valid = 1'b1; ld_entry_pid = 16'h1;
        ld_entry_vpn = 52'h10; ld_entry_acc = 12'h111; ld_entry_nvalid = 1'b1; ld_entry_next = 6'd9;
        @(negedge clk);
        req_valid = 1'b0; ld_entry_we = 1'b0;
        wait_rsp();
        chk("R7 err", r_err, 1);
        chk("R7 hit", r_hit, 0);
        chk("R7 steps", r_steps, NFR);
        extra = 0;
        for (int n = 0; n < 6; n++) begin
            @(negedge clk);
            if (rsp_valid) extra++;
        end
        chk("R8 busy request ignored", extra, 0);
        lookup(16'h1, 52'h10, 12'h0, 1'b0, '0);
        chk("R9 busy write dropped", r_acc, 12'hABC);
    endtask

    task automatic t_same_cycle(input logic [AAW-1:0] s);
        lookup(16'h1, 52'h10, 12'h0, 1'b1, s);
        chk("R10 old slot used", r_hit, 1);
        chk("R10 old slot ppn", r_ppn, 5);
        lookup(16'h1, 52'h10, 12'h0, 1'b0, '0);
        chk("R10 new slot hit", r_hit, 0);
        chk("R10 new slot steps", r_steps, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [AAW-1:0] s_a, s_g, s_h;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        for (int i = 0; i < (1 << AAW); i++) load_anchor(AAW'(i), 1'b0, '0);
        for (int i = 0; i < NFR; i++) load_entry(FAW'(i), 1'b0, '0, '0, '0, 1'b0, '0);
        s_a = model_slot(16'h1, 52'h10);   // R2 slot shared by vpn 0x10, 0x01, 0x32 (pid 1)
        s_g = model_slot(16'h0, 52'h4);
        s_h = model_slot(16'h0, 52'h8);
        load_anchor(s_a, 1'b1, 6'd5);
        load_entry(6'd5, 1'b1, 16'h1, 52'h10, 12'hABC, 1'b1, 6'd9);
        load_entry(6'd9, 1'b1, 16'h2, 52'h01, 12'h222, 1'b1, 6'd20);
        load_entry(6'd20, 1'b1, 16'h1, 52'h01, 12'h333, 1'b0, 6'd0);
        load_anchor(s_g, 1'b1, 6'd30);
        load_anchor(s_h, 1'b1, 6'd40);
        load_entry(6'd40, 1'b1, 16'h7, 52'h77, 12'h0, 1'b1, 6'd41);
        load_entry(6'd41, 1'b1, 16'h7, 52'h78, 12'h0, 1'b1, 6'd40);
        t_first_hit();
        t_chain();
        t_anchor_invalid();
        t_chain_end();
        t_cycle_busy();
        t_same_cycle(s_a);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule